// File: doc/BRIEF.md
# FEAC Codeword Transmitter

This block produces the serial bit stream for the far-end alarm and control channel of a DS3 C-bit frame. Two six-bit codes, A and B, are held in write-only registers. A start strobe, together with a pattern-select input and a repeat count, launches a message. The message is code A repeated, code B repeated, or code A repeated followed by code B repeated. Each code is framed as a 16-bit codeword. When no message is in progress, the output carries continuous ones.

The serializer moves forward one bit for each pulse of a slot-enable input. The surrounding framer raises that input once for every C-bit slot that belongs to this channel. The block reports whether it is idle through a live status bit. It also keeps a sticky idle flag that records each return to idle. Software clears the flag by writing a one to it.

Top module: `feac_tx`

## Requirements
- R1: After reset, `feac_out` is 1, `idle_live` is 1 and `idle_latched` is 1.
- R2: Each codeword is 16 bits, sent in this order: a 0, code bits 0 through 5 (bit 0 first), a 0, then eight 1s.
- R3: Whenever no codeword is in progress, `feac_out` is 1.
- R4: `idle_live` goes to 0 on the clock edge that accepts a start. It goes back to 1 on the edge that consumes the final bit of the message.
- R5: `start_mode` encoding: 0 sends code A only, 1 sends code B only, 2 sends code A N times and then code B N times. A start with value 3 is ignored.
- R6: Each codeword of a message is sent N times, where N is `rep_count`. A count of 0 is treated as 1.
- R7: The bit shown on `feac_out` advances only on a clock edge where `bit_en` is 1. It holds for as long as `bit_en` is 0.
- R8: A code write (`code_wr_sel` 0 selects A, 1 selects B) takes effect from the next codeword boundary onward. The codeword that is already being sent is not affected.
- R9: A start raised while a message is in progress is ignored.
- R10: `idle_latched` becomes 1 on the edge where `idle_live` rises. It stays 1 until it is cleared.
- R11: A pulse on `idle_clr` clears `idle_latched` on the next edge. If a return to idle happens on that same edge, the flag is set instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| code_wr_en | input | 1 | Write strobe for the code registers |
| code_wr_sel | input | 1 | Target of the write: 0 is code A, 1 is code B |
| code_wr_data | input | 6 | Six-bit code value to write |
| start | input | 1 | Starts a message when the block is idle |
| start_mode | input | 2 | Pattern select, sampled with `start` |
| rep_count | input | 4 | Number of times each codeword is sent, sampled with `start` |
| bit_en | input | 1 | Slot enable; one pulse consumes one bit |
| idle_clr | input | 1 | Write-one-to-clear for the sticky idle flag |
| feac_out | output | 1 | Serial FEAC bit |
| idle_live | output | 1 | 1 when idle, 0 while a message is being sent |
| idle_latched | output | 1 | Sticky flag recording a return to idle |

## Verification
The bench writes a code in the middle of a codeword. A design that reloads its shift word on every write would corrupt the remaining bits of that word, and the bench would see the change before the boundary. The bench also raises the clear in the same cycle as the final bit, so that the clear and a return to idle land on one edge; a design that gives the clear priority would read 0 there. It pulses `start` on gap cycles during a message, uses the reserved mode, and uses a repeat count of 0. A design that restarts, drops into an illegal state, or sends nothing would break the expected bit stream. Random gaps in `bit_en` show whether the output holds between slots or slips to the next bit.

// File: rtl/feac_tx_pkg.sv
package feac_tx_pkg;

    localparam int CODE_W = 6;
    localparam int WORD_W = 16;
    localparam int POS_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {
        MODE_A   = 2'd0,
        MODE_B   = 2'd1,
        MODE_AB  = 2'd2,
        MODE_RSV = 2'd3
    } feac_mode_e;

    // Bit index 0 leaves first: 0, code[0..5], 0, then ones.
    function automatic logic [WORD_W-1:0] frame_word(input logic [CODE_W-1:0] code);
        return {{(WORD_W-CODE_W-2){1'b1}}, 1'b0, code, 1'b0};
    endfunction

endpackage

// File: rtl/feac_code_regs.sv
module feac_code_regs
    import feac_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [CODE_W-1:0] wr_data,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b
);

    localparam int N_CODES = 2;

    typedef struct packed {
        logic [N_CODES-1:0][CODE_W-1:0] code;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < N_CODES; i++) begin
            if (wr_en && (int'(wr_sel) == i)) begin
                regs_d.code[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign code_a = regs_q.code[0];
    assign code_b = regs_q.code[1];

endmodule

// File: rtl/feac_word_ctrl.sv
module feac_word_ctrl
    import feac_tx_pkg::*;
#(
    parameter int REP_W = 4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode_in,
    input  logic [REP_W-1:0]  rep_in,
    input  logic              bit_en,
    input  logic [CODE_W-1:0] code_a,
    input  logic [CODE_W-1:0] code_b,
    output logic              ser_bit,
    output logic              busy,
    output logic              done
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_W - 1);
    localparam logic [REP_W-1:0] ONE_REP  = REP_W'(1);

    typedef struct packed {
        logic              busy;
        logic              phase_b;
        feac_mode_e        mode;
        logic [REP_W-1:0]  rep_total;
        logic [REP_W-1:0]  reps_left;
        logic [POS_W-1:0]  pos;
        logic [WORD_W-1:0] word;
    } ctrl_t;

    ctrl_t      st_d, st_q;
    feac_mode_e req_mode;
    logic       cur_b;
    logic [REP_W-1:0] eff_rep;

    always_comb begin
        st_d     = st_q;
        done     = 1'b0;
        req_mode = feac_mode_e'(mode_in);
        eff_rep  = (rep_in == '0) ? ONE_REP : rep_in;
        cur_b    = (st_q.mode == MODE_B) || st_q.phase_b;

        if (!st_q.busy) begin
            if (start && (req_mode != MODE_RSV)) begin
                st_d.busy      = 1'b1;
                st_d.mode      = req_mode;
                st_d.phase_b   = 1'b0;
                st_d.rep_total = eff_rep;
                st_d.reps_left = eff_rep;
                st_d.pos       = '0;
                st_d.word      = frame_word((req_mode == MODE_B) ? code_b : code_a);
            end
        end else if (bit_en) begin
            if (st_q.pos == LAST_POS) begin
                st_d.pos = '0;
                if (st_q.reps_left > ONE_REP) begin
                    st_d.reps_left = st_q.reps_left - ONE_REP;
                    st_d.word      = frame_word(cur_b ? code_b : code_a);
                end else if ((st_q.mode == MODE_AB) && !st_q.phase_b) begin
                    st_d.phase_b   = 1'b1;
                    st_d.reps_left = st_q.rep_total;
                    st_d.word      = frame_word(code_b);
                end else begin
                    st_d.busy = 1'b0;
                    done      = 1'b1;
                end
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MODE_A;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_bit = st_q.word[st_q.pos];
    assign busy    = st_q.busy;

    // R7: position and word hold without a slot enable
    p_hold_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !bit_en) |=> ($stable(st_q.pos) && $stable(st_q.word)));

    // R2: the two framing zeros at bit indexes 0 and 7
    p_frame_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && ((st_q.pos == '0) || (st_q.pos == POS_W'(7)))) |-> !ser_bit);

    // R6: a running message never has a zero repeat count
    p_rep_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.reps_left != '0));

    // R9: a start while busy leaves the message pattern unchanged
    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && start) |=> $stable(st_q.mode));

endmodule

// File: rtl/feac_idle_status.sv
module feac_idle_status (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic done,
    input  logic idle_clr,
    output logic idle_live,
    output logic idle_latched
);

    typedef struct packed {
        logic latched;
    } stat_t;

    stat_t stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (done) begin
            stat_d.latched = 1'b1;
        end else if (idle_clr) begin
            stat_d.latched = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q.latched <= 1'b1;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign idle_live    = !busy;
    assign idle_latched = stat_q.latched;

    // R11: a clear with no coincident return to idle empties the flag
    p_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_clr && !done) |=> !idle_latched);

    // R10: the flag is sticky until cleared
    p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_latched && !idle_clr) |=> idle_latched);

endmodule

// File: rtl/feac_tx.sv
module feac_tx
    import feac_tx_pkg::*;
#(
    parameter int REP_W = 4
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             code_wr_en,
    input  logic             code_wr_sel,
    input  logic [5:0]       code_wr_data,
    input  logic             start,
    input  logic [1:0]       start_mode,
    input  logic [REP_W-1:0] rep_count,
    input  logic             bit_en,
    input  logic             idle_clr,
    output logic             feac_out,
    output logic             idle_live,
    output logic             idle_latched
);

    logic [CODE_W-1:0] code_a, code_b;
    logic              ser_bit, busy, done;

    feac_code_regs i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (code_wr_en),
        .wr_sel  (code_wr_sel),
        .wr_data (code_wr_data),
        .code_a  (code_a),
        .code_b  (code_b)
    );

    feac_word_ctrl #(.REP_W(REP_W)) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mode_in (start_mode),
        .rep_in  (rep_count),
        .bit_en  (bit_en),
        .code_a  (code_a),
        .code_b  (code_b),
        .ser_bit (ser_bit),
        .busy    (busy),
        .done    (done)
    );

    feac_idle_status i_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy         (busy),
        .done         (done),
        .idle_clr     (idle_clr),
        .idle_live    (idle_live),
        .idle_latched (idle_latched)
    );

    assign feac_out = busy ? ser_bit : 1'b1;

    // R3: idle output is all ones
    p_idle_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        idle_live |-> feac_out);

    // R10: a return to idle is recorded in the sticky flag
    p_latch_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_live) |-> idle_latched);

endmodule

// File: tb/test_feac_tx.sv
module test_feac_tx;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       code_wr_en = 1'b0;
    logic       code_wr_sel = 1'b0;
    logic [5:0] code_wr_data = '0;
    logic       start = 1'b0;
    logic [1:0] start_mode = '0;
    logic [3:0] rep_count = '0;
    logic       bit_en = 1'b0;
    logic       idle_clr = 1'b0;
    logic       feac_out, idle_live, idle_latched;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [5:0] sh_a = '0;
    logic [5:0] sh_b = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    feac_tx i_feac_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .code_wr_en   (code_wr_en),
        .code_wr_sel  (code_wr_sel),
        .code_wr_data (code_wr_data),
        .start        (start),
        .start_mode   (start_mode),
        .rep_count    (rep_count),
        .bit_en       (bit_en),
        .idle_clr     (idle_clr),
        .feac_out     (feac_out),
        .idle_live    (idle_live),
        .idle_latched (idle_latched)
    );

    function automatic logic [15:0] exp_word(input logic [5:0] c);
        logic [15:0] w;
        w = '1;
        w[0] = 1'b0;
        for (int i = 0; i < 6; i++) w[1+i] = c[i];
        w[7] = 1'b0;
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        bit_en = 1'b0; start = 1'b0; code_wr_en = 1'b0; idle_clr = 1'b0;
    endtask

    task automatic write_code(input logic sel, input logic [5:0] d);
        tick();
        code_wr_en = 1'b1; code_wr_sel = sel; code_wr_data = d;
        tick();
        if (sel) sh_b = d; else sh_a = d;
    endtask

    task automatic send(input logic [1:0] m, input logic [3:0] rep, input int gapmax,
                        input int wr_at, input logic wsel, input logic [5:0] wdat,
                        input int clr_at, input bit stray, input bit clr_end);
        int n, total, g;
        logic [15:0] cur;
        bit sel_b;
        n = (rep == 0) ? 1 : int'(rep);
        total = (m == 2'd2) ? 2*n : n;
        g = 0;
        tick();
        start = 1'b1; start_mode = m; rep_count = rep;
        tick();
        chk("R4 idle_live low after start", idle_live, 0);
        for (int w = 0; w < total; w++) begin
            sel_b = (m == 2'd1) || ((m == 2'd2) && (w >= n));
            cur = exp_word(sel_b ? sh_b : sh_a);
            for (int b = 0; b < 16; b++) begin
                int gaps;
                gaps = $urandom_range(gapmax, 0);
                for (int k = 0; k < gaps; k++) begin
                    chk("R7 hold without bit_en", feac_out, cur[b]);
                    if (stray && k == 0) begin
                        start = 1'b1; start_mode = 2'd1;  // R9 stray start
                    end
                    tick();
                end
                chk(sel_b ? "R2 R5 R6 code B bit" : "R2 R5 R6 code A bit", feac_out, cur[b]);
                if (b == 0) chk("R4 idle_live low while sending", idle_live, 0);
                bit_en = 1'b1;
                if (g == wr_at) begin
                    code_wr_en = 1'b1; code_wr_sel = wsel; code_wr_data = wdat;
                end
                if (g == clr_at) idle_clr = 1'b1;
                if (clr_end && (w == total-1) && (b == 15)) idle_clr = 1'b1;
                tick();
                if (g == wr_at) begin
                    if (wsel) sh_b = wdat; else sh_a = wdat;
                end
                if (g == clr_at) chk("R11 clear while sending", idle_latched, 0);
                g++;
            end
        end
        chk("R3 ones after message", feac_out, 1);
        chk("R4 idle_live high after last bit", idle_live, 1);
        chk(clr_end ? "R11 set wins over clear" : "R10 latched on return to idle", idle_latched, 1);
        tick();
        chk("R3 ones while idle", feac_out, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 feac_out after reset", feac_out, 1);
        chk("R1 idle_live after reset", idle_live, 1);
        chk("R1 idle_latched after reset", idle_latched, 1);

        // R11 clear while idle, R10 stays clear with no new event
        tick(); idle_clr = 1'b1; tick();
        chk("R11 clear while idle", idle_latched, 0);
        tick(); tick();
        chk("R10 no spurious set", idle_latched, 0);

        // R5 reserved mode is ignored
        tick(); start = 1'b1; start_mode = 2'd3; rep_count = 4'd2; tick();
        chk("R5 reserved mode ignored", idle_live, 1);
        chk("R3 ones after reserved start", feac_out, 1);
        chk("R10 reserved start no latch change", idle_latched, 0);

        write_code(1'b0, 6'b100101);
        write_code(1'b1, 6'b011100);

        // R6 repeat of ten, back-to-back slots
        send(2'd0, 4'd10, 0, -1, 1'b0, '0, -1, 1'b0, 1'b0);
        // R8 write to B in the middle of the first B codeword
        send(2'd1, 4'd2, 2, 5, 1'b1, 6'b110011, -1, 1'b0, 1'b0);
        // R5 A then B, R11 set priority at last bit, clear mid-message
        send(2'd2, 4'd3, 1, 20, 1'b0, 6'b000001, 3, 1'b0, 1'b1);
        // R9 stray starts while busy
        send(2'd1, 4'd2, 3, -1, 1'b0, '0, -1, 1'b1, 1'b0);
        // R6 count zero sends once
        send(2'd0, 4'd0, 1, -1, 1'b0, '0, -1, 1'b0, 1'b0);

        for (int r = 0; r < 25; r++) begin
            logic [1:0] m;
            logic [3:0] rp;
            int wa, ca;
            m  = 2'($urandom_range(2, 0));
            rp = 4'($urandom_range(15, 0));
            wa = $urandom_range(40, 0);
            if ((wa % 16) == 15) wa = -1;
            ca = $urandom_range(1) ? 2 : -1;
            send(m, rp, 2, wa, 1'($urandom_range(1, 0)), 6'($urandom), ca,
                 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule